// File: doc/BRIEF.md
# Slow-Infrared Frame Transmitter

This block turns a stream of payload bytes into the serial bit stream of a slow-infrared link frame. A frame opens when a byte marked as start-of-frame is offered. The block then sends a preamble of start flags. The number of flags and the filler byte come from two configuration inputs, which are sampled once as the frame opens. After the preamble it takes the payload bytes through a valid/ready handshake and escapes any byte that would look like a flag. It then appends a CRC-16 over the raw payload, escaped in the same way, and closes the frame with a stop flag.

Every byte goes out as ten bit periods: a start bit, eight data bits least significant first, and a stop bit. One bit period lasts from one baud tick to the next. The baud tick is a one-cycle strobe from outside, so the rate can be set anywhere up to 115200 baud. The output is the raw line bit, before any LED pulse shaping. A busy output stays high from the moment a frame opens until the last stop bit has ended, so that the local infrared receiver can be held off while the block transmits.

Top module: `sir_frame_tx`

## Requirements
- R1: With a preamble count of 0, the frame starts with exactly one C0h byte, followed directly by the payload.
- R2: With a preamble count N from 1 to 15, the frame starts with N filler bytes followed by one C0h. The filler is C0h when the filler-select input is 0 and FFh when it is 1.
- R3: A payload byte equal to C0h, C1h or 7Dh goes out as 7Dh followed by the byte XOR 20h. Every other payload byte goes out unchanged.
- R4: After the payload come two CRC bytes: the low byte first, then the high byte. The CRC is the ones' complement of a CRC-CCITT (polynomial 1021h, processed bit-reflected with constant 8408h). It starts from FFFFh and runs LSB first over the unescaped payload bytes.
- R5: Each CRC byte follows the escape rule of R3.
- R6: The frame ends with a single stop flag C1h after the CRC bytes.
- R7: Each byte occupies ten bit periods, one per baud tick: a low start bit, eight data bits LSB first, and a high stop bit. The line rests high between bytes and between frames.
- R8: `tx_busy` goes high when a frame opens and stays high until the stop bit of the stop flag has ended. While `tx_busy` is low, `txd` is high.
- R9: `in_ready` is low while preamble flags are sent and while an escaped byte's second byte is still pending. Each payload byte is accepted only once the previous byte has gone out in full.
- R10: Outside a frame, a byte offered without the start-of-frame marker is accepted and dropped. Nothing is transmitted and `tx_busy` stays low.
- R11: The preamble count and filler select are sampled when the frame opens. Changes later in the frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| cfg_pre_count | input | 4 | Number of filler flags before the final C0h |
| cfg_pre_ff | input | 1 | Filler select: 0 for C0h, 1 for FFh |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| txd | output | 1 | Serial line bit |
| tx_busy | output | 1 | Frame in progress; holds the receiver disabled |

## Verification
The hardest case to reach is an escaped CRC byte, because the CRC can only be steered through the payload. The bench searches all 256 single-byte payloads with its own CRC model. It picks one whose complemented CRC has a reserved low or high byte, and sends that frame. The bench also checks the stall after escaped payload bytes by timing the gap between handshakes against two full byte periods, and it changes the configuration inputs mid-frame.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_OPEN  = 8'hC0;
  localparam logic [BYTE_W-1:0] FLAG_CLOSE = 8'hC1;
  localparam logic [BYTE_W-1:0] FLAG_ESC   = 8'h7D;
  localparam logic [BYTE_W-1:0] FILL_ONES  = 8'hFF;
  localparam logic [BYTE_W-1:0] ESC_FLIP   = 8'h20;
  localparam logic [15:0] CRC_POLY_REFL    = 16'h8408;
  localparam logic [15:0] CRC_PRESET       = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_OPEN, ST_DATA, ST_CRC_LO, ST_CRC_HI, ST_CLOSE, ST_DRAIN
  } fr_state_e;

  function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
    return (b == FLAG_OPEN) || (b == FLAG_CLOSE) || (b == FLAG_ESC);
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [BYTE_W-1:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < BYTE_W; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/sir_crc16.sv
module sir_crc16
  import sir_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              en,
  input  logic [BYTE_W-1:0] data,
  output logic [15:0]       crc
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)    crc_d = CRC_PRESET;
    else if (en) crc_d = crc_step(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            crc_q <= CRC_PRESET;
    else if (init || en)   crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R4: the running CRC only moves on a preset or an accepted payload byte
  assert_crc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(init || en) |=> $stable(crc_q));
endmodule

// File: rtl/sir_byte_serializer.sv
module sir_byte_serializer
  import sir_tx_pkg::*;
#(
  parameter int FRAME_BITS = BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              ready,
  output logic              txd
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                  active_q, active_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  txd_q, txd_d;

  always_comb begin
    active_d = active_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    txd_d    = txd_q;
    if (!active_q) begin
      txd_d = 1'b1;
      if (load) begin
        active_d = 1'b1;
        sh_d     = {1'b1, byte_in, 1'b0};
        cnt_d    = '0;
      end
    end else if (baud_tick) begin
      if (cnt_q == CNT_W'(FRAME_BITS)) begin
        active_d = 1'b0;
        txd_d    = 1'b1;
      end else begin
        txd_d = sh_q[0];
        sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '1;
      cnt_q    <= '0;
      txd_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      txd_q    <= txd_d;
    end
  end

  assign ready = !active_q;
  assign txd   = txd_q;

  // R7: a new byte is never loaded over one still being shifted out
  assert_load_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active_q);
  // R7: the line rests high whenever no byte is in flight
  assert_idle_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |=> txd_q);
endmodule

// File: rtl/sir_frame_ctrl.sv
module sir_frame_ctrl
  import sir_tx_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRE_W-1:0]  cfg_pre_count,
  input  logic              cfg_pre_ff,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  input  logic              ser_ready,
  output logic              ser_load,
  output logic [BYTE_W-1:0] ser_byte,
  input  logic [15:0]       crc,
  output logic              crc_init,
  output logic              crc_en,
  output logic              busy
);
  fr_state_e         st_q, st_d, ret_q, ret_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              ff_q, ff_d;
  logic              esc_q, esc_d;
  logic [BYTE_W-1:0] eb_q, eb_d;
  logic [15:0]       crc_tx;

  assign crc_tx = ~crc;

  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    pre_d    = pre_q;
    ff_d     = ff_q;
    esc_d    = esc_q;
    eb_d     = eb_q;
    in_ready = 1'b0;
    ser_load = 1'b0;
    ser_byte = FLAG_OPEN;
    crc_init = 1'b0;
    crc_en   = 1'b0;

    if (esc_q) begin
      if (ser_ready) begin
        ser_load = 1'b1;
        ser_byte = eb_q;
        esc_d    = 1'b0;
        st_d     = ret_q;
      end
    end else begin
      case (st_q)
        ST_IDLE: begin
          in_ready = !in_sof;
          if (in_valid && in_sof) begin
            pre_d    = cfg_pre_count;
            ff_d     = cfg_pre_ff;
            crc_init = 1'b1;
            st_d     = (cfg_pre_count == '0) ? ST_OPEN : ST_PRE;
          end
        end
        ST_PRE: if (ser_ready) begin
          ser_load = 1'b1;
          ser_byte = ff_q ? FILL_ONES : FLAG_OPEN;
          pre_d    = pre_q - 1'b1;
          if (pre_q == PRE_W'(1)) st_d = ST_OPEN;
        end
        ST_OPEN: if (ser_ready) begin
          ser_load = 1'b1;
          ser_byte = FLAG_OPEN;
          st_d     = ST_DATA;
        end
        ST_DATA: begin
          in_ready = ser_ready;
          if (in_valid && ser_ready) begin
            crc_en   = 1'b1;
            ser_load = 1'b1;
            if (is_reserved(in_data)) begin
              ser_byte = FLAG_ESC;
              esc_d    = 1'b1;
              eb_d     = in_data ^ ESC_FLIP;
              ret_d    = in_eof ? ST_CRC_LO : ST_DATA;
            end else begin
              ser_byte = in_data;
              if (in_eof) st_d = ST_CRC_LO;
            end
          end
        end
        ST_CRC_LO, ST_CRC_HI: if (ser_ready) begin
          ser_load = 1'b1;
          ser_byte = (st_q == ST_CRC_LO) ? crc_tx[7:0] : crc_tx[15:8];
          if (is_reserved(ser_byte)) begin
            esc_d    = 1'b1;
            eb_d     = ser_byte ^ ESC_FLIP;
            ret_d    = (st_q == ST_CRC_LO) ? ST_CRC_HI : ST_CLOSE;
            ser_byte = FLAG_ESC;
          end else begin
            st_d = (st_q == ST_CRC_LO) ? ST_CRC_HI : ST_CLOSE;
          end
        end
        ST_CLOSE: if (ser_ready) begin
          ser_load = 1'b1;
          ser_byte = FLAG_CLOSE;
          st_d     = ST_DRAIN;
        end
        ST_DRAIN: if (ser_ready) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ret_q <= ST_IDLE;
      pre_q <= '0;
      ff_q  <= 1'b0;
      esc_q <= 1'b0;
      eb_q  <= '0;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
      pre_q <= pre_d;
      ff_q  <= ff_d;
      esc_q <= esc_d;
      eb_q  <= eb_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R9: no payload byte is taken while an escaped byte's second half waits
  assert_ready_low_on_escape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    esc_q |-> !in_ready);
  // R9: no payload byte is taken while the serializer is still busy in a frame
  assert_ready_needs_idle_ser_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_ready) |-> ser_ready);
  // R11: the latched preamble settings stay put once the preamble is over
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA && !esc_q) |=> $stable(ff_q));
endmodule

// File: rtl/sir_frame_tx.sv
module sir_frame_tx
  import sir_tx_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [PRE_W-1:0]  cfg_pre_count,
  input  logic              cfg_pre_ff,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_busy
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              ser_ready, ser_load;
  logic [BYTE_W-1:0] ser_byte;
  logic [15:0]       crc;
  logic              crc_init, crc_en;
  logic              ctrl_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sir_frame_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int),
    .cfg_pre_count(cfg_pre_count), .cfg_pre_ff(cfg_pre_ff),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready),
    .ser_ready(ser_ready), .ser_load(ser_load), .ser_byte(ser_byte),
    .crc(crc), .crc_init(crc_init), .crc_en(crc_en),
    .busy(ctrl_busy)
  );

  sir_crc16 u_crc (
    .clk(clk), .rst_n(rst_n_int),
    .init(crc_init), .en(crc_en), .data(in_data), .crc(crc)
  );

  sir_byte_serializer u_ser (
    .clk(clk), .rst_n(rst_n_int), .baud_tick(baud_tick),
    .load(ser_load), .byte_in(ser_byte), .ready(ser_ready), .txd(txd)
  );

  assign tx_busy = ctrl_busy;

  // R8: the serializer is never active outside a busy period
  assert_ser_within_busy_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ser_ready |-> tx_busy);
  // R8: the line is high whenever no frame is in progress
  assert_line_high_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    !tx_busy |-> txd);
endmodule

// File: tb/tb_sir_frame_tx.sv
module tb_sir_frame_tx;
  import sir_tx_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int BYTE_CYC = 10 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0;
  logic [3:0] cfg_pre_count = '0;
  logic cfg_pre_ff = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_sof = 1'b0, in_eof = 1'b0;
  logic in_ready, txd, tx_busy;

  int checks = 0, fails = 0;
  int cyc = 0;
  int div_cnt = 0;
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] pay[$];
  int acc_cyc[$];
  int frame_err = 0, busy_err = 0;
  int dec_st = 0;
  logic [7:0] dec_sh;

  sir_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_pre_count(cfg_pre_count), .cfg_pre_ff(cfg_pre_ff),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .txd(txd), .tx_busy(tx_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tick generation and UART decoding share one process, away from the edge
  always @(negedge clk) begin
    if (baud_tick) begin
      if (dec_st == 0) begin
        if (!txd) dec_st = 1;
      end else if (dec_st <= 8) begin
        dec_sh = {txd, dec_sh[7:1]};
        dec_st = dec_st + 1;
      end else begin
        if (!txd) frame_err = frame_err + 1;
        rx_q.push_back(dec_sh);
        dec_st = 0;
      end
      if (dec_st != 0 && !tx_busy) busy_err = busy_err + 1;
    end
    baud_tick = (div_cnt == DIV - 1);
    div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      c = c ^ {8'h00, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic bit rsv(input logic [7:0] b);
    return b == 8'hC0 || b == 8'hC1 || b == 8'h7D;
  endfunction

  task automatic push_esc(input logic [7:0] b);
    if (rsv(b)) begin exp_q.push_back(8'h7D); exp_q.push_back(b ^ 8'h20); end
    else exp_q.push_back(b);
  endtask

  task automatic build_exp(input int n, input bit ff);
    logic [15:0] c;
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back(ff ? 8'hFF : 8'hC0);
    exp_q.push_back(8'hC0);
    foreach (pay[i]) push_esc(pay[i]);
    c = ref_crc(pay);
    push_esc(c[7:0]);
    push_esc(c[15:8]);
    exp_q.push_back(8'hC1);
  endtask

  // Sends pay[] as one frame and compares the decoded line bytes
  task automatic run_frame(input string req, input int n, input bit ff, input bit flip_cfg);
    int start;
    rx_q.delete(); acc_cyc.delete();
    frame_err = 0; busy_err = 0;
    build_exp(n, ff);
    @(negedge clk);
    cfg_pre_count = 4'(n); cfg_pre_ff = ff;
    start = cyc;
    foreach (pay[i]) begin
      in_valid = 1'b1; in_data = pay[i];
      in_sof = (i == 0); in_eof = (i == pay.size() - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk); #1;
        if (flip_cfg && tx_busy) begin cfg_pre_count = 4'(15 - n); cfg_pre_ff = !ff; end
      end
      @(negedge clk);
      acc_cyc.push_back(cyc);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    while (tx_busy) @(negedge clk);
    chk(dec_st == 0, "R8", "busy fell before last stop bit ended", dec_st, 0);
    repeat (2 * BYTE_CYC) @(negedge clk);
    chk(rx_q.size() == exp_q.size(), req, "frame byte count", rx_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
      chk(rx_q[i] == exp_q[i], req, $sformatf("byte %0d", i), rx_q[i], exp_q[i]);
    chk(frame_err == 0, "R7", "stop bit low", frame_err, 0);
    chk(busy_err == 0, "R8", "busy low mid-byte", busy_err, 0);
    chk(acc_cyc[0] - start >= (n + 1) * BYTE_CYC, "R9", "payload accepted during preamble",
        acc_cyc[0] - start, (n + 1) * BYTE_CYC);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R8", "txd at reset", txd, 1);
    chk(tx_busy == 1'b0, "R8", "busy at reset", tx_busy, 0);
  endtask

  task automatic t_plain();
    pay = '{8'h12, 8'h34, 8'h56};
    run_frame("R1 R4 R6", 0, 1'b0, 1'b0);
  endtask

  task automatic t_pre_c0();
    pay = '{8'hA5, 8'h00};
    run_frame("R2", 3, 1'b0, 1'b0);
  endtask

  task automatic t_pre_ff_cfg_change();
    pay = '{8'h01, 8'h02, 8'hFE};
    run_frame("R2 R11", 5, 1'b1, 1'b1);
  endtask

  task automatic t_escape();
    pay = '{8'hC0, 8'h41, 8'hC1, 8'h7D, 8'h7C};
    run_frame("R3", 1, 1'b0, 1'b0);
    chk(acc_cyc[1] - acc_cyc[0] >= 2 * BYTE_CYC, "R9", "ready gap after escaped byte",
        acc_cyc[1] - acc_cyc[0], 2 * BYTE_CYC);
    chk(acc_cyc[2] - acc_cyc[1] >= BYTE_CYC, "R9", "ready gap after plain byte",
        acc_cyc[2] - acc_cyc[1], BYTE_CYC);
  endtask

  task automatic t_crc_escape();
    logic [7:0] one[$];
    logic [15:0] c;
    int found = -1;
    for (int b = 0; b < 256 && found < 0; b++) begin
      one = '{8'(b)};
      c = ref_crc(one);
      if (rsv(c[7:0]) || rsv(c[15:8])) found = b;
    end
    chk(found >= 0, "R5", "payload with reserved CRC byte found", found, 0);
    if (found >= 0) begin
      pay = '{8'(found)};
      run_frame("R5", 0, 1'b0, 1'b0);
    end
  endtask

  task automatic t_stray();
    rx_q.delete();
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h55; in_sof = 1'b0; in_eof = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R10", "stray byte ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 3 * BYTE_CYC; i++) begin
      @(negedge clk);
      if (tx_busy || !txd) begin
        chk(1'b0, "R10", "activity after stray byte", {tx_busy, txd}, 1);
        break;
      end
    end
    chk(rx_q.size() == 0, "R10", "bytes sent for stray byte", rx_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_pre_c0();
    t_pre_ff_cfg_change();
    t_escape();
    t_crc_escape();
    t_stray();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule